// File: doc/BRIEF.md
# Serial Start Code Detector

The block watches one sampled, active-high binary input and flags when it carries a programmed start pattern. A pattern is a string of up to 32 symbols. Each symbol lasts one nominal time: a 1 means the input is active for that time and a 0 means it is idle. Equal neighbouring symbols merge into one level whose length is that many nominal times.

The detector splits the input into runs of constant level and times each run with a tick from a programmable prescaler. It then checks each run against the next expected run of the pattern. The accepted window for a run of k symbols is the minimum time times k up to the maximum time times k. Two pattern slots, normal and alternative, are checked side by side. A status register shows which slot matched, and a maskable interrupt output follows it. After a match, searching pauses until software clears the status and writes the enable bit again.

Register map (word index on `reg_addr_i`):
- 0 control: bit 0 enables; bit 1 restarts.
- 1 prescaler.
- 2 normal code.
- 3 alternative code.
- 4 lengths.
- 5 minimum time.
- 6 nominal time.
- 7 maximum time.
- 8 interrupt enable (bit 0).
- 9 interrupt clear (bit 0, write 1).
- 10 status (read).

Reads return data combinationally.

Top module: `start_code_detector`

## Requirements
- R1: After reset the status register reads 0, the control register reads 0, and `det_o` and `irq_o` are low.
- R2: With detection enabled, an input whose runs follow the normal code sets status bit 0. The code is taken most significant symbol first; a 1 symbol is active input and a 0 symbol is idle input. A run of k equal symbols must last between k·min and k·max ticks. A final run counts as soon as it has lasted k·nominal ticks.
- R3: A match of the alternative code sets status bit 1. When both registers hold the same code and length, one pattern sets both bits (status 3).
- R4: In the length register, bits [4:0] give the normal code length and bits [12:8] give the alternative length. The value 0 means 32 symbols. Code bits above the programmed length are ignored.
- R5: A run that falls outside its k·min to k·max window drops the match back to the first symbol. That same run is then tried as the first run of the pattern. A correct pattern that follows a broken one is still found.
- R6: An input whose run order or run lengths differ from the code produces no status bit.
- R7: A match clears the enable bit. No further status bit is set until status is cleared (write 1 to the clear register) and detection is enabled again.
- R8: With the enable bit at 0, no pattern sets a status bit.
- R9: Writing the control register with bit 1 set discards any partial match. Bit 0 of the same write sets the enable.
- R10: The timing tick comes every P clock cycles, where P is the prescaler value. Values 0 and 1 both give a tick every cycle.
- R11: `irq_o` is high when interrupt-enable bit 0 is set and status is non-zero. `det_o` is high whenever status is non-zero, whatever the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Sampled input, 1 = active |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| det_o | output | 1 | Any code matched |
| irq_o | output | 1 | Masked match interrupt |

## Verification
The main function is swept over every 5-symbol code that starts and ends with an active symbol. Each code is tried against all eight such patterns, first in the normal slot and then in the alternative slot. Any pair that differs has the same total length, so it can only fail through run order or length; this separates true matches from near misses in either slot. Directed patterns then do three things:
- They stretch and shrink single runs to exactly one tick on either side of their windows, which checks the tolerance bounds.
- They place a broken pattern directly before a correct one, which checks the restart-and-retry path.
- They exercise a 32-symbol code selected by length 0, a short code with junk in its upper bits, and a prescaler of 4 driven with and without stretched timing.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int MAX_SYM = 32;
  localparam int SYM_W   = $clog2(MAX_SYM);
  localparam int POS_W   = $clog2(MAX_SYM + 1);
  localparam int REG_W   = 32;
  localparam int LEN_ALT_LSB = 8;

  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_PRESC  = 4'd1,
    A_CODE_N = 4'd2,
    A_CODE_A = 4'd3,
    A_LEN    = 4'd4,
    A_TMIN   = 4'd5,
    A_TNOM   = 4'd6,
    A_TMAX   = 4'd7,
    A_IEN    = 4'd8,
    A_ICLR   = 4'd9,
    A_STAT   = 4'd10
  } reg_addr_e;

  typedef struct packed {
    logic             lvl;
    logic [POS_W-1:0] n;
  } run_t;

  function automatic logic [POS_W-1:0] len_decode(input logic [SYM_W-1:0] f);
    return (f == '0) ? POS_W'(MAX_SYM) : POS_W'(f);
  endfunction

  // level and symbol count of the run starting at symbol pos (pos 0 = msb of code)
  function automatic run_t run_at(input logic [MAX_SYM-1:0] code,
                                  input logic [POS_W-1:0]   len,
                                  input logic [POS_W-1:0]   pos);
    run_t r;
    logic go;
    int   top;
    top   = int'(len) - 1 - int'(pos);
    r.lvl = (top >= 0) ? code[SYM_W'(top)] : 1'b0;
    r.n   = '0;
    go    = 1'b1;
    for (int i = 0; i < MAX_SYM; i++) begin
      if (go && (top - i >= 0) && (code[SYM_W'(top - i)] == r.lvl)) r.n = r.n + 1'b1;
      else go = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/scd_timebase.sv
module scd_timebase #(
  parameter int PRE_W = 16,
  parameter int DUR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             lvl_o,
  output logic             edge_o,
  output logic [DUR_W:0]   dur_o
);
  logic [PRE_W-1:0] pcnt_q;
  logic [DUR_W-1:0] dur_q;
  logic             rx_q;
  logic             tick;

  assign tick   = (presc_i <= PRE_W'(1)) || (pcnt_q >= presc_i - PRE_W'(1));
  assign lvl_o  = rx_q;
  assign edge_o = rx_i != rx_q;
  // ticks spent at the current level, counting this cycle
  assign dur_o  = {1'b0, dur_q} + (DUR_W+1)'(tick);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      dur_q  <= '0;
      rx_q   <= 1'b0;
    end else begin
      pcnt_q <= tick ? '0 : pcnt_q + PRE_W'(1);
      rx_q   <= rx_i;
      if (edge_o)                   dur_q <= '0;
      else if (tick && dur_q != '1) dur_q <= dur_q + DUR_W'(1);
    end
  end

  a_r10_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presc_i > PRE_W'(1) && $stable(presc_i) && $past(tick)) |-> !tick);
endmodule

// File: rtl/scd_matcher.sv
module scd_matcher
  import scd_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int DUR_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               edge_i,
  input  logic               lvl_i,
  input  logic [DUR_W:0]     dur_i,
  input  logic [MAX_SYM-1:0] code_i,
  input  logic [POS_W-1:0]   len_i,
  input  logic [TIME_W-1:0]  tmin_i,
  input  logic [TIME_W-1:0]  tnom_i,
  input  logic [TIME_W-1:0]  tmax_i,
  output logic               hit_o
);
  localparam int CMP_W = TIME_W + POS_W + DUR_W + 1;

  logic [POS_W-1:0] pos_q, pos_d;
  run_t             rp, r0;
  logic [CMP_W-1:0] dur, lo_p, hi_p, nom_p, lo_0, hi_0;
  logic             fit_p, fit_0, last_p, last_0, reach_p;

  always_comb begin
    rp    = run_at(code_i, len_i, pos_q);
    r0    = run_at(code_i, len_i, '0);
    dur   = CMP_W'(dur_i);
    lo_p  = CMP_W'(tmin_i) * CMP_W'(rp.n);
    hi_p  = CMP_W'(tmax_i) * CMP_W'(rp.n);
    nom_p = CMP_W'(tnom_i) * CMP_W'(rp.n);
    lo_0  = CMP_W'(tmin_i) * CMP_W'(r0.n);
    hi_0  = CMP_W'(tmax_i) * CMP_W'(r0.n);
    fit_p = edge_i && lvl_i == rp.lvl && rp.n != '0 && dur >= lo_p && dur <= hi_p;
    fit_0 = edge_i && lvl_i == r0.lvl && r0.n != '0 && dur >= lo_0 && dur <= hi_0;
    last_p  = ({1'b0, pos_q} + {1'b0, rp.n}) == {1'b0, len_i};
    last_0  = {1'b0, r0.n} == {1'b0, len_i};
    // final run is accepted once it has lasted its nominal time
    reach_p = lvl_i == rp.lvl && rp.n != '0 && dur >= nom_p;
    hit_o   = !clr_i && ((last_p && (fit_p || reach_p)) || (!fit_p && fit_0 && last_0));

    pos_d = pos_q;
    if (clr_i) pos_d = '0;
    else if (edge_i) begin
      if (fit_p && !last_p)      pos_d = pos_q + rp.n;
      else if (!fit_p && fit_0 && !last_0) pos_d = r0.n;
      else if (!fit_p)           pos_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  a_r5_pos_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= POS_W'(MAX_SYM));
  a_r9_clear_rewinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pos_q == '0);
endmodule

// File: rtl/start_code_detector.sv
module start_code_detector
  import scd_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int PRE_W  = 16,
  parameter int DUR_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             reg_we_i,
  input  logic [3:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             det_o,
  output logic             irq_o
);
  localparam int NSLOT = 2;

  logic               en_q, ien_q;
  logic [PRE_W-1:0]   presc_q;
  logic [TIME_W-1:0]  tmin_q, tnom_q, tmax_q;
  logic [MAX_SYM-1:0] code_q [NSLOT];
  logic [SYM_W-1:0]   lenf_q [NSLOT];
  logic [NSLOT-1:0]   status_q, hit;
  logic               lvl, edge_s, search, restart, clr_wr;
  logic [DUR_W:0]     dur;

  assign restart = reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[1];
  assign clr_wr  = reg_we_i && reg_addr_i == A_ICLR && reg_wdata_i[0];
  assign search  = en_q && status_q == '0;
  assign det_o   = |status_q;
  assign irq_o   = ien_q && det_o;

  scd_timebase #(.PRE_W(PRE_W), .DUR_W(DUR_W)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .presc_i(presc_q),
    .lvl_o(lvl), .edge_o(edge_s), .dur_o(dur)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    scd_matcher #(.TIME_W(TIME_W), .DUR_W(DUR_W)) u_m (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!search || restart),
      .edge_i(edge_s), .lvl_i(lvl), .dur_i(dur),
      .code_i(code_q[g]), .len_i(len_decode(lenf_q[g])),
      .tmin_i(tmin_q), .tnom_i(tnom_q), .tmax_i(tmax_q),
      .hit_o(hit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; ien_q <= 1'b0; presc_q <= '0;
      tmin_q <= '0; tnom_q <= '0; tmax_q <= '0;
      status_q <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        code_q[i] <= '0;
        lenf_q[i] <= '0;
      end
    end else begin
      if (search && |hit) begin
        status_q <= hit;
        en_q     <= 1'b0;
      end else if (clr_wr) status_q <= '0;
      if (reg_we_i) begin
        case (reg_addr_i)
          A_CTRL:   en_q      <= reg_wdata_i[0];
          A_PRESC:  presc_q   <= reg_wdata_i[PRE_W-1:0];
          A_CODE_N: code_q[0] <= reg_wdata_i[MAX_SYM-1:0];
          A_CODE_A: code_q[1] <= reg_wdata_i[MAX_SYM-1:0];
          A_LEN: begin
            lenf_q[0] <= reg_wdata_i[SYM_W-1:0];
            lenf_q[1] <= reg_wdata_i[LEN_ALT_LSB +: SYM_W];
          end
          A_TMIN:   tmin_q    <= reg_wdata_i[TIME_W-1:0];
          A_TNOM:   tnom_q    <= reg_wdata_i[TIME_W-1:0];
          A_TMAX:   tmax_q    <= reg_wdata_i[TIME_W-1:0];
          A_IEN:    ien_q     <= reg_wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:   reg_rdata_o[0] = en_q;
      A_PRESC:  reg_rdata_o[PRE_W-1:0] = presc_q;
      A_CODE_N: reg_rdata_o[MAX_SYM-1:0] = code_q[0];
      A_CODE_A: reg_rdata_o[MAX_SYM-1:0] = code_q[1];
      A_LEN: begin
        reg_rdata_o[SYM_W-1:0] = lenf_q[0];
        reg_rdata_o[LEN_ALT_LSB +: SYM_W] = lenf_q[1];
      end
      A_TMIN:   reg_rdata_o[TIME_W-1:0] = tmin_q;
      A_TNOM:   reg_rdata_o[TIME_W-1:0] = tnom_q;
      A_TMAX:   reg_rdata_o[TIME_W-1:0] = tmax_q;
      A_IEN:    reg_rdata_o[0] = ien_q;
      A_STAT:   reg_rdata_o[NSLOT-1:0] = status_q;
      default: ;
    endcase
  end

  a_r2_normal_sets_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (search && hit[0]) |=> status_q[0]);
  a_r3_alt_sets_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (search && hit[1]) |=> status_q[1]);
  a_r7_status_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q != '0 && !clr_wr) |=> status_q == $past(status_q));
  a_r8_no_set_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && status_q == '0) |=> status_q == '0);
endmodule

// File: tb/start_code_detector_bench.sv
module start_code_detector_bench;
  import scd_pkg::*;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        det, irq;
  int          n_vec = 0, n_err = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  start_code_detector u_start_code_detector (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .det_o(det), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic hold(input logic lv, input int cyc);
    rx = lv;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic idle();
    hold(1'b0, 60);
  endtask

  task automatic send(input logic [31:0] code, input int len, input int cps);
    for (int i = len - 1; i >= 0; i--) hold(code[i], cps);
    idle();
  endtask

  task automatic status_is(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(A_STAT, d);
    chk(tag, d, exp);
  endtask

  task automatic rearm();
    wr(A_ICLR, 32'h1);
    wr(A_CTRL, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    status_is("R1 status", 0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    chk("R1 det", det, 0);
    chk("R1 irq", irq, 0);

    wr(A_PRESC, 1); wr(A_TMIN, 8); wr(A_TNOM, 10); wr(A_TMAX, 12); wr(A_IEN, 1);

    // R2/R6 sweep over the normal slot; alt holds an unreachable 6-symbol code
    wr(A_CODE_A, 32'b110011); wr(A_LEN, (6 << 8) | 5);
    for (int ci = 0; ci < 8; ci++) begin
      wr(A_CODE_N, 17 + 2 * ci);
      for (int pi = 0; pi < 8; pi++) begin
        rearm(); idle();
        send(17 + 2 * pi, 5, 10);
        status_is("R2 R6 normal sweep", (ci == pi) ? 1 : 0);
        chk("R11 irq normal sweep", irq, (ci == pi) ? 1 : 0);
      end
    end

    // R3 sweep over the alternative slot
    wr(A_CODE_N, 32'b110011); wr(A_LEN, (5 << 8) | 6);
    for (int ci = 0; ci < 8; ci++) begin
      wr(A_CODE_A, 17 + 2 * ci);
      for (int pi = 0; pi < 8; pi++) begin
        rearm(); idle();
        send(17 + 2 * pi, 5, 10);
        status_is("R3 alt sweep", (ci == pi) ? 2 : 0);
      end
    end

    // R3 identical codes set both bits
    wr(A_CODE_N, 32'b11011); wr(A_CODE_A, 32'b11011); wr(A_LEN, (5 << 8) | 5);
    rearm(); send(32'b11011, 5, 10);
    status_is("R3 identical", 3);

    // R4 length 0 means 32 symbols
    wr(A_CODE_N, 32'hAAAA_AAAB); wr(A_CODE_A, 32'b110011); wr(A_LEN, (6 << 8) | 0);
    rearm(); send(32'hAAAA_AAAB, 32, 10);
    status_is("R4 len32", 1);
    // R4 upper code bits ignored
    wr(A_CODE_N, 32'h1234_567D); wr(A_LEN, (6 << 8) | 4);
    rearm(); send(32'b1101, 4, 10);
    status_is("R4 short code", 1);

    // R5 tolerance boundaries on code 1101 (mark 2, space 1, mark 1)
    wr(A_CODE_N, 32'b1101); wr(A_CODE_A, 32'b1011); wr(A_LEN, (4 << 8) | 4);
    rearm(); hold(1, 16); hold(0, 10); hold(1, 10); idle();
    status_is("R5 mark at 2*min", 1);
    rearm(); hold(1, 15); hold(0, 10); hold(1, 10); idle();
    status_is("R5 mark below 2*min", 0);
    rearm(); hold(1, 24); hold(0, 10); hold(1, 10); idle();
    status_is("R5 mark at 2*max", 1);
    rearm(); hold(1, 25); hold(0, 10); hold(1, 10); idle();
    status_is("R5 mark above 2*max", 0);
    rearm(); hold(1, 20); hold(0, 7); hold(1, 10); idle();
    status_is("R5 short space", 0);
    rearm(); hold(1, 20); hold(0, 8); hold(1, 10); idle();
    status_is("R5 space at min", 1);
    rearm(); hold(1, 15); hold(0, 10); hold(1, 20); hold(0, 10); hold(1, 10); idle();
    status_is("R5 retry after broken run", 1);

    // R7 search paused after a match
    rearm(); send(32'b1101, 4, 10);
    status_is("R7 first match", 1);
    send(32'b1011, 4, 10);
    status_is("R7 held while flagged", 1);
    wr(A_ICLR, 1);
    status_is("R7 cleared", 0);
    chk("R7 irq cleared", irq, 0);
    send(32'b1011, 4, 10);
    status_is("R7 not re-enabled", 0);
    wr(A_CTRL, 1); send(32'b1011, 4, 10);
    status_is("R7 re-enabled alt", 2);

    // R8 disabled
    wr(A_ICLR, 1); wr(A_CTRL, 0);
    send(32'b1101, 4, 10);
    status_is("R8 disabled", 0);

    // R9 restart mid-pattern
    wr(A_CTRL, 1); idle();
    hold(1, 20); hold(0, 4);
    wr(A_CTRL, 3);
    hold(0, 4); hold(1, 10); idle();
    status_is("R9 restart drops partial", 0);
    rd(A_CTRL, d); chk("R9 enable kept", d, 1);
    send(32'b1101, 4, 10);
    status_is("R9 full after restart", 1);

    // R10 prescaler
    wr(A_PRESC, 4); rearm(); idle();
    send(32'b1101, 4, 40);
    status_is("R10 presc 4 scaled", 1);
    rearm(); send(32'b1101, 4, 10);
    status_is("R10 presc 4 unscaled", 0);
    wr(A_PRESC, 0); rearm(); idle();
    send(32'b1101, 4, 10);
    status_is("R10 presc 0", 1);

    // R11 interrupt mask
    wr(A_IEN, 0); rearm(); send(32'b1101, 4, 10);
    chk("R11 det unmasked", det, 1);
    chk("R11 irq masked", irq, 0);
    wr(A_IEN, 1); @(negedge clk);
    chk("R11 irq enabled", irq, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule